// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a watchdog that counts down once per incoming tick from a programmable timeout. If software misses the first deadline, the block sets a status flag, optionally raises a system-management interrupt, and starts counting again. If a second deadline passes with no reload in between, the block records a second-timeout event and asks for a system reset. A strap input or a no-reboot input can hold off that reset. In that case the timer keeps running and the interrupt path stays active.

Software talks to the block through a small register bus. The bus takes byte or halfword accesses and is little-endian. Besides the timer registers, the bus holds a data-in byte that raises the interrupt, a data-out byte that sets a status flag, and some plain scratch registers. The tick comes from an external prescaler through `tick_en`. Reads of the bus are combinational. Writes take effect on the clock edge where `bus_wr` is high.

Register map. The address is a byte address. Halfword accesses use even addresses.
- 0x00 reload
- 0x02 data-in
- 0x03 data-out
- 0x04 status 1
- 0x06 status 2
- 0x08 control 1
- 0x0A control 2
- 0x0C message 1
- 0x0D message 2
- 0x0E watchdog scratch (1 byte)
- 0x10 timeout (10 bits)
- 0x12 software-interrupt byte

Anything else reads as zero and ignores writes.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, control 2 reads 0x0008, timeout reads 0x0004, the software-interrupt byte reads 0x03, and every other register reads 0. The timer is stopped and both pulse outputs are low.
- R2: The timer starts only on a write to reload or control 1, and only when the halt bit (control 1 bit 11) is clear and the timeout is greater than 1. A timeout of 0 or 1 never starts it.
- R3: While the timer runs, each cycle with `tick_en` high lowers the count by one. A tick that arrives when the count is 1 or less is an expiry. A read of reload while running returns the live count in bits [9:0] and the stored upper bits above it. A read while stopped returns the stored value.
- R4: Each expiry sets status 1 bit 3. When no reset is taken, an expiry pulses `smi_o` for one cycle if `smi_en` is high, stores the timeout into reload, and restarts the count from the timeout.
- R5: The second consecutive expiry sets status 2 bits 1 and 2 and clears the expiry count. If `strap_hold` and `no_reboot` are both low, the block pulses `reset_req_o` for one cycle, stops the timer and clears reload. It raises no `smi_o` for that expiry.
- R6: If `strap_hold` or `no_reboot` is high at the second expiry, no reset request is made. The timer restarts, and `smi_o` follows `smi_en` as for a first expiry.
- R7: Any write to reload clears the expiry count. If running is allowed, the count restarts from the timeout. Otherwise the written value is stored, and a timer that is already running keeps running. A write to reload or control 1 in the same cycle as a tick takes priority, and that tick causes no expiry.
- R8: Control 1 stores only bits [12:8]. Bit 12 is a lock that software can set but never clear. A write to control 1 restarts the timer when running is allowed, and stops it otherwise.
- R9: A write to the data-in byte stores it, sets status 1 bit 1 and pulses `smi_o` on the next cycle. A write to the data-out byte stores it and sets status 1 bit 2.
- R10: A write to status 1 stores the value masked with 0x000E. A write to status 2 stores the value masked with 0x0006.
- R11: A byte access uses bits [7:0] of the data bus and selects the low byte of a halfword register at an even address and the high byte at an odd address. A halfword access moves all 16 bits. Byte-wide registers read 0 in their unused byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data; bytes use bits [7:0] |
| bus_rdata | output | 16 | Combinational read data |
| tick_en | input | 1 | Countdown tick qualifier |
| smi_en | input | 1 | Allows timeout interrupts |
| strap_hold | input | 1 | High holds off the reset request |
| no_reboot | input | 1 | High holds off the reset request |
| smi_o | output | 1 | One-cycle interrupt pulse |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions run on every cycle and check these properties:
- A reset request is only one cycle long and only follows a cycle where both hold-off inputs were low.
- A reset request always leaves the timer stopped.
- The timer never starts while halted or with a timeout below 2.
- A set halt bit always means a stopped timer.
- The lock bit never falls.

Some behaviours need bench scenarios with known stimulus and reads. These are the exact tick on which each expiry lands, the two-strike sequence and its status bits, how a reload write clears the strike count, the overlay of the live count on reload reads, the status masks, the data-in and data-out side effects, and byte-lane placement.

// File: rtl/wdog_pkg.sv
// Shared constants and helpers for the two-strike watchdog.
// Assumes a 16-bit register slot per even byte address.
package wdog_pkg;

    localparam int NSLOT     = 10;
    localparam int SLOT_AW   = 4;

    // Register slot indices (byte address / 2)
    localparam int SL_RELOAD = 0;
    localparam int SL_DATA   = 1;
    localparam int SL_STAT1  = 2;
    localparam int SL_STAT2  = 3;
    localparam int SL_CTRL1  = 4;
    localparam int SL_CTRL2  = 5;
    localparam int SL_MSG    = 6;
    localparam int SL_SCR    = 7;
    localparam int SL_TMO    = 8;
    localparam int SL_SWIRQ  = 9;

    // Bit positions
    localparam int ST1_SWSMI  = 1;
    localparam int ST1_DOUT   = 2;
    localparam int ST1_EXPIRE = 3;
    localparam int ST2_SECOND = 1;
    localparam int ST2_BOOT   = 2;
    localparam int C1_HALT    = 11;
    localparam int C1_LOCK    = 12;

    // Masks and reset values
    localparam logic [15:0] ST1_MASK  = 16'h000E;
    localparam logic [15:0] ST2_MASK  = 16'h0006;
    localparam logic [15:0] C1_MASK   = 16'h1F00;
    localparam logic [15:0] C2_RST    = 16'h0008;
    localparam logic [15:0] TMO_RST   = 16'h0004;
    localparam logic [7:0]  SWIRQ_RST = 8'h03;

    // Number of consecutive expiries that request a reset
    localparam int STRIKE_LIMIT = 2;
    localparam int STRIKE_W     = $clog2(STRIKE_LIMIT + 1);

    // Merge lane-aligned new data into an old halfword under byte enables
    function automatic logic [15:0] lane_merge(input logic [15:0] old_v,
                                               input logic [15:0] new_v,
                                               input logic [1:0]  be);
        return {be[1] ? new_v[15:8] : old_v[15:8],
                be[0] ? new_v[7:0]  : old_v[7:0]};
    endfunction

endpackage

// File: rtl/wdog_busdec.sv
// Write-side decode of the register bus.
// Turns address and size into one-hot slot strobes, byte enables and
// lane-aligned data. Assumes halfword accesses use even addresses.
module wdog_busdec
    import wdog_pkg::*;
(
    input  logic             bus_wr,
    input  logic             bus_half,
    input  logic [4:0]       bus_addr,
    input  logic [15:0]      bus_wdata,
    output logic [NSLOT-1:0] wr_sel,
    output logic [1:0]       wr_be,
    output logic [15:0]      wr_data
);

    logic [SLOT_AW-1:0] slot_idx;

    assign slot_idx = bus_addr[4:1];

    // One strobe per implemented slot
    for (genvar g = 0; g < NSLOT; g++) begin : g_sel
        assign wr_sel[g] = bus_wr && (slot_idx == SLOT_AW'(g));
    end

    // Byte enables and lane placement from access size and address bit 0
    always_comb begin
        if (bus_half) begin
            wr_be   = 2'b11;
            wr_data = bus_wdata;
        end else if (bus_addr[0]) begin
            wr_be   = 2'b10;
            wr_data = {bus_wdata[7:0], 8'h00};
        end else begin
            wr_be   = 2'b01;
            wr_data = {8'h00, bus_wdata[7:0]};
        end
    end

endmodule

// File: rtl/wdog_core.sv
// Countdown, strike counting and output pulses of the watchdog.
// Assumes at most one register write per cycle. A write to reload or
// control 1 in a cycle takes priority over a tick in that cycle.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          smi_en,
    input  logic          strap_hold,
    input  logic          no_reboot,
    input  logic          wr_reload,
    input  logic          wr_ctrl1,
    input  logic          halt_eff,
    input  logic [TW-1:0] tmo,
    input  logic          din_wr,
    output logic          run,
    output logic [TW-1:0] cnt,
    output logic          restart,
    output logic          expire,
    output logic          second,
    output logic          take_reset,
    output logic          smi_o,
    output logic          reset_req_o
);

    logic                can_run;
    logic                stop_w;
    logic                ctl_wr;
    logic [STRIKE_W-1:0] strikes_q;
    logic                run_q;
    logic [TW-1:0]       cnt_q;

    assign ctl_wr     = wr_reload || wr_ctrl1;
    assign can_run    = !halt_eff && (tmo > TW'(1));
    assign restart    = ctl_wr && can_run;
    assign stop_w     = wr_ctrl1 && !can_run;
    assign expire     = run_q && tick_en && (cnt_q <= TW'(1)) && !ctl_wr;
    assign second     = expire && (strikes_q == STRIKE_W'(STRIKE_LIMIT - 1));
    assign take_reset = second && !strap_hold && !no_reboot;
    assign run        = run_q;
    assign cnt        = cnt_q;

    // Run flag and countdown value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (restart) begin
            run_q <= 1'b1;
            cnt_q <= tmo;
        end else if (stop_w) begin
            run_q <= 1'b0;
        end else if (expire) begin
            if (take_reset) run_q <= 1'b0;
            else            cnt_q <= tmo;
        end else if (run_q && tick_en) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // Consecutive-expiry count, cleared by reload writes and by the last strike
    always_ff @(posedge clk) begin
        if (!rst_n)          strikes_q <= '0;
        else if (wr_reload)  strikes_q <= '0;
        else if (second)     strikes_q <= '0;
        else if (expire)     strikes_q <= strikes_q + STRIKE_W'(1);
    end

    // Registered single-cycle interrupt and reset pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_o       <= 1'b0;
            reset_req_o <= 1'b0;
        end else begin
            smi_o       <= (expire && !take_reset && smi_en) || din_wr;
            reset_req_o <= take_reset;
        end
    end

endmodule

// File: rtl/wdog_regs.sv
// Register storage of the watchdog, with the side effects of writes and
// of expiry events. Assumes the events from the core are mutually
// consistent: an expiry never coincides with a reload or control 1 write.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] wr_sel,
    input  logic [1:0]       wr_be,
    input  logic [15:0]      wr_data,
    input  logic             restart,
    input  logic             expire,
    input  logic             second,
    input  logic             take_reset,
    output logic             halt_eff,
    output logic [TW-1:0]    tmo_q,
    output logic [15:0]      ctrl1_q,
    output logic [NSLOT-1:0][15:0] slot_val
);

    logic [15:0] reload_q, st1_q, st2_q, ctrl2_q;
    logic [7:0]  din_q, dout_q, msg1_q, msg2_q, scr_q, swirq_q;
    logic [15:0] st1_n, st2_n, ctrl1_wr, tmo_ext;
    logic        din_wr, dout_wr;

    assign tmo_ext  = 16'(tmo_q);
    assign din_wr   = wr_sel[SL_DATA] && wr_be[0];
    assign dout_wr  = wr_sel[SL_DATA] && wr_be[1];
    assign ctrl1_wr = (lane_merge(ctrl1_q, wr_data, wr_be) & C1_MASK)
                    | (ctrl1_q & (16'h1 << C1_LOCK));
    assign halt_eff = wr_sel[SL_CTRL1] ? ctrl1_wr[C1_HALT] : ctrl1_q[C1_HALT];

    // Status 1: event bits accumulate, a write replaces under mask
    always_comb begin
        st1_n = st1_q;
        if (din_wr)  st1_n[ST1_SWSMI]  = 1'b1;
        if (dout_wr) st1_n[ST1_DOUT]   = 1'b1;
        if (expire)  st1_n[ST1_EXPIRE] = 1'b1;
        if (wr_sel[SL_STAT1]) st1_n = lane_merge(st1_q, wr_data, wr_be) & ST1_MASK;
    end

    // Status 2: second-strike bits accumulate, a write replaces under mask
    always_comb begin
        st2_n = st2_q;
        if (second) begin
            st2_n[ST2_SECOND] = 1'b1;
            st2_n[ST2_BOOT]   = 1'b1;
        end
        if (wr_sel[SL_STAT2]) st2_n = lane_merge(st2_q, wr_data, wr_be) & ST2_MASK;
    end

    // Reload register: cleared or refilled by events, else written by software
    always_ff @(posedge clk) begin
        if (!rst_n)                 reload_q <= '0;
        else if (expire)            reload_q <= take_reset ? 16'h0 : tmo_ext;
        else if (restart)           reload_q <= tmo_ext;
        else if (wr_sel[SL_RELOAD]) reload_q <= lane_merge(reload_q, wr_data, wr_be);
    end

    // Status and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1_q   <= '0;
            st2_q   <= '0;
            ctrl1_q <= '0;
            ctrl2_q <= C2_RST;
            tmo_q   <= TMO_RST[TW-1:0];
        end else begin
            st1_q <= st1_n;
            st2_q <= st2_n;
            if (wr_sel[SL_CTRL1]) ctrl1_q <= ctrl1_wr;
            if (wr_sel[SL_CTRL2]) ctrl2_q <= lane_merge(ctrl2_q, wr_data, wr_be);
            if (wr_sel[SL_TMO])   tmo_q   <= lane_merge(tmo_ext, wr_data, wr_be)[TW-1:0];
        end
    end

    // Byte-wide data, message, scratch and software-interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q   <= '0;
            dout_q  <= '0;
            msg1_q  <= '0;
            msg2_q  <= '0;
            scr_q   <= '0;
            swirq_q <= SWIRQ_RST;
        end else begin
            if (din_wr)                           din_q   <= wr_data[7:0];
            if (dout_wr)                          dout_q  <= wr_data[15:8];
            if (wr_sel[SL_MSG] && wr_be[0])       msg1_q  <= wr_data[7:0];
            if (wr_sel[SL_MSG] && wr_be[1])       msg2_q  <= wr_data[15:8];
            if (wr_sel[SL_SCR] && wr_be[0])       scr_q   <= wr_data[7:0];
            if (wr_sel[SL_SWIRQ] && wr_be[0])     swirq_q <= wr_data[7:0];
        end
    end

    // Halfword view of every slot for the read path
    always_comb begin
        slot_val            = '0;
        slot_val[SL_RELOAD] = reload_q;
        slot_val[SL_DATA]   = {dout_q, din_q};
        slot_val[SL_STAT1]  = st1_q;
        slot_val[SL_STAT2]  = st2_q;
        slot_val[SL_CTRL1]  = ctrl1_q;
        slot_val[SL_CTRL2]  = ctrl2_q;
        slot_val[SL_MSG]    = {msg2_q, msg1_q};
        slot_val[SL_SCR]    = {8'h00, scr_q};
        slot_val[SL_TMO]    = tmo_ext;
        slot_val[SL_SWIRQ]  = {8'h00, swirq_q};
    end

endmodule

// File: rtl/wdog_rdmux.sv
// Combinational read path. It overlays the live count on the reload slot
// while the timer runs, then selects the byte lane.
// Assumes TW is less than 16.
module wdog_rdmux
    import wdog_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic             bus_half,
    input  logic [4:0]       bus_addr,
    input  logic [NSLOT-1:0][15:0] slot_val,
    input  logic             run,
    input  logic [TW-1:0]    cnt,
    output logic [15:0]      bus_rdata
);

    logic [SLOT_AW-1:0] idx;
    logic [15:0]        hw;

    assign idx = bus_addr[4:1];

    // Slot select with live-count overlay on the reload slot
    always_comb begin
        hw = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (idx == SLOT_AW'(i)) hw = slot_val[i];
        end
        if (run && idx == SLOT_AW'(SL_RELOAD)) hw = {hw[15:TW], cnt};
    end

    // Byte lane select
    always_comb begin
        if (bus_half)         bus_rdata = hw;
        else if (bus_addr[0]) bus_rdata = {8'h00, hw[15:8]};
        else                  bus_rdata = {8'h00, hw[7:0]};
    end

endmodule

// File: rtl/wdog_twostage.sv
// Top of the two-strike watchdog. It joins the bus decode, register
// storage, countdown core and read path. Assumes one access per cycle.
// The tick prescaler and interrupt routing live outside this block.
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int TMR_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_half,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        tick_en,
    input  logic        smi_en,
    input  logic        strap_hold,
    input  logic        no_reboot,
    output logic        smi_o,
    output logic        reset_req_o
);

    logic [NSLOT-1:0]       wr_sel;
    logic [1:0]             wr_be;
    logic [15:0]            wr_data;
    logic [NSLOT-1:0][15:0] slot_val;
    logic [TMR_W-1:0]       tmo_q, core_cnt;
    logic [15:0]            ctrl1_q;
    logic                   halt_eff, core_run, restart, expire, second, take_reset;

    wdog_busdec u_dec (
        .bus_wr    (bus_wr),
        .bus_half  (bus_half),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_sel    (wr_sel),
        .wr_be     (wr_be),
        .wr_data   (wr_data)
    );

    wdog_regs #(.TW(TMR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .wr_be      (wr_be),
        .wr_data    (wr_data),
        .restart    (restart),
        .expire     (expire),
        .second     (second),
        .take_reset (take_reset),
        .halt_eff   (halt_eff),
        .tmo_q      (tmo_q),
        .ctrl1_q    (ctrl1_q),
        .slot_val   (slot_val)
    );

    wdog_core #(.TW(TMR_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .smi_en      (smi_en),
        .strap_hold  (strap_hold),
        .no_reboot   (no_reboot),
        .wr_reload   (wr_sel[SL_RELOAD]),
        .wr_ctrl1    (wr_sel[SL_CTRL1]),
        .halt_eff    (halt_eff),
        .tmo         (tmo_q),
        .din_wr      (wr_sel[SL_DATA] && wr_be[0]),
        .run         (core_run),
        .cnt         (core_cnt),
        .restart     (restart),
        .expire      (expire),
        .second      (second),
        .take_reset  (take_reset),
        .smi_o       (smi_o),
        .reset_req_o (reset_req_o)
    );

    wdog_rdmux #(.TW(TMR_W)) u_rd (
        .bus_half  (bus_half),
        .bus_addr  (bus_addr),
        .slot_val  (slot_val),
        .run       (core_run),
        .cnt       (core_cnt),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/wdog_twostage_chk.sv
// Property checker for the watchdog, bound to the top module.
// Watches the pulse outputs, the run flag and the control bits.
module wdog_twostage_chk #(
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strap_hold,
    input logic          no_reboot,
    input logic          reset_req,
    input logic          run,
    input logic          halt,
    input logic          lock,
    input logic [TW-1:0] tmo
);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);                                        // R5
    AST_RST_STOPS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !run);                                              // R5
    AST_RST_NOT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(!strap_hold && !no_reboot));                  // R6
    AST_START_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (!halt && tmo > TW'(1)));                          // R2
    AST_HALT_MEANS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !run);                                                   // R8
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);                                                   // R8

endmodule

bind wdog_twostage wdog_twostage_chk #(.TW(TMR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_hold (strap_hold),
    .no_reboot  (no_reboot),
    .reset_req  (reset_req_o),
    .run        (core_run),
    .halt       (ctrl1_q[11]),
    .lock       (ctrl1_q[12]),
    .tmo        (tmo_q)
);

// File: tb/test_wdog_twostage.sv
`timescale 1ns/1ps
module test_wdog_twostage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_half = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        smi_en = 1'b0;
    logic        strap_hold = 1'b0;
    logic        no_reboot = 1'b0;
    logic        smi_o, reset_req_o;

    int checks = 0;
    int errors = 0;
    int smi_seen, rst_seen;
    logic [15:0] rv;

    always #4 clk = ~clk;

    wdog_twostage i_wdog_twostage (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_half(bus_half),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .smi_en(smi_en), .strap_hold(strap_hold),
        .no_reboot(no_reboot), .smi_o(smi_o), .reset_req_o(reset_req_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic half, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_half = half; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic half, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_half = half;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        smi_seen = 0; rst_seen = 0;
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (smi_o) smi_seen++;
            if (reset_req_o) rst_seen++;
        end
        tick_en = 1'b0;
    endtask

    // Model of plain registers: writable byte mask per slot
    function automatic logic [15:0] plain_mask(input int s);
        case (s)
            5: return 16'hFFFF;
            6: return 16'hFFFF;
            7: return 16'h00FF;
            default: return 16'h00FF;
        endcase
    endfunction

    function automatic logic [15:0] model_write(input logic [15:0] old, input int s,
                                                input logic half, input logic odd,
                                                input logic [15:0] d);
        logic [15:0] nv;
        if (half)     nv = d;
        else if (odd) nv = {d[7:0], old[7:0]};
        else          nv = {old[15:8], d[7:0]};
        return (nv & plain_mask(s)) | (old & ~plain_mask(s));
    endfunction

    initial begin : watchdog
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] model [4];
        int unused_seed;
        unused_seed = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        chk("R1 pulses idle", {14'h0, smi_o, reset_req_o}, 16'h0);
        rd(5'h00, 1, rv); chk("R1 reload", rv, 16'h0000);
        rd(5'h04, 1, rv); chk("R1 status1", rv, 16'h0000);
        rd(5'h08, 1, rv); chk("R1 ctrl1", rv, 16'h0000);
        rd(5'h0A, 1, rv); chk("R1 ctrl2", rv, 16'h0008);
        rd(5'h10, 1, rv); chk("R1 timeout", rv, 16'h0004);
        rd(5'h12, 0, rv); chk("R1 swirq byte", rv, 16'h0003);
        ticks(8); chk("R1 stopped after reset", 16'(smi_seen + rst_seen), 16'h0);

        // R2 small timeouts and halt never start
        smi_en = 1'b1;
        wr(5'h10, 1, 16'h0001); wr(5'h08, 1, 16'h0000);
        ticks(10); chk("R2 timeout 1 no start", 16'(smi_seen), 16'h0);
        rd(5'h00, 1, rv); chk("R2 reload stored", rv, 16'h0000);
        wr(5'h10, 1, 16'h0000); wr(5'h00, 1, 16'h0000);
        ticks(10); chk("R2 timeout 0 no start", 16'(smi_seen), 16'h0);
        wr(5'h10, 1, 16'h0005); wr(5'h08, 1, 16'h0800);
        ticks(10); chk("R2 halt no start", 16'(smi_seen), 16'h0);
        rd(5'h04, 1, rv); chk("R2 no expiry flag", rv, 16'h0000);

        // R3/R4 countdown and first expiry
        wr(5'h08, 1, 16'h0000);
        rd(5'h00, 1, rv); chk("R3 live count start", rv, 16'h0005);
        ticks(2); rd(5'h00, 1, rv); chk("R3 live count after 2", rv, 16'h0003);
        ticks(2); chk("R3 no early expiry", 16'(smi_seen), 16'h0);
        ticks(1); chk("R4 first expiry smi", 16'(smi_seen), 16'h1);
        chk("R4 no reset on first", 16'(rst_seen), 16'h0);
        rd(5'h04, 1, rv); chk("R4 status1 expiry bit", rv, 16'h0008);
        rd(5'h00, 1, rv); chk("R4 restarted", rv, 16'h0005);

        // R5 second expiry takes reset
        ticks(5); chk("R5 reset pulse", 16'(rst_seen), 16'h1);
        chk("R5 no smi on reset", 16'(smi_seen), 16'h0);
        rd(5'h06, 1, rv); chk("R5 status2 bits", rv, 16'h0006);
        rd(5'h00, 1, rv); chk("R5 reload cleared, stopped", rv, 16'h0000);
        ticks(12); chk("R5 timer stopped", 16'(smi_seen + rst_seen), 16'h0);

        // R6 hold-off by strap, then by no_reboot
        wr(5'h04, 1, 16'h0000); wr(5'h06, 1, 16'h0000);
        strap_hold = 1'b1;
        wr(5'h08, 1, 16'h0000);
        ticks(10); chk("R6 strap no reset", 16'(rst_seen), 16'h0);
        chk("R6 strap smi both", 16'(smi_seen), 16'h2);
        rd(5'h06, 1, rv); chk("R6 strap status2", rv, 16'h0006);
        strap_hold = 1'b0; no_reboot = 1'b1;
        wr(5'h06, 1, 16'h0000); wr(5'h00, 1, 16'h0000);
        ticks(10); chk("R6 no_reboot no reset", 16'(rst_seen), 16'h0);
        chk("R6 no_reboot smi both", 16'(smi_seen), 16'h2);
        rd(5'h06, 1, rv); chk("R6 no_reboot status2", rv, 16'h0006);
        smi_en = 1'b0;
        ticks(5); chk("R4 smi_en low masks smi", 16'(smi_seen), 16'h0);

        // R7 reload write clears strike count
        no_reboot = 1'b0; smi_en = 1'b1;
        wr(5'h00, 1, 16'h0000);
        ticks(5); chk("R7 strike one", 16'(rst_seen), 16'h0);
        wr(5'h00, 1, 16'h0000);
        ticks(5); chk("R7 cleared strike no reset", 16'(rst_seen), 16'h0);
        chk("R7 cleared strike smi", 16'(smi_seen), 16'h1);
        ticks(5); chk("R7 then reset", 16'(rst_seen), 16'h1);
        // R7 same-cycle reload write suppresses an expiry tick
        wr(5'h00, 1, 16'h0000); ticks(4);
        @(negedge clk); tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00;
        bus_half = 1'b1; bus_wdata = 16'h0;
        @(posedge clk); #1; tick_en = 1'b0; bus_wr = 1'b0;
        chk("R7 write beats tick", {15'h0, smi_o}, 16'h0);
        rd(5'h00, 1, rv); chk("R7 write restarted count", rv, 16'h0005);
        wr(5'h08, 1, 16'h0800);
        wr(5'h00, 1, 16'hA5C3);
        rd(5'h00, 1, rv); chk("R7 stored when stopped", rv, 16'hA5C3);

        // R8 lock and control 1 mask
        wr(5'h08, 1, 16'h1000);
        rd(5'h08, 1, rv); chk("R8 lock set", rv, 16'h1000);
        rd(5'h00, 1, rv); chk("R8 ctrl1 write restarts", rv, 16'h0005);
        wr(5'h08, 1, 16'h0800);
        rd(5'h08, 1, rv); chk("R8 lock kept", rv, 16'h1800);
        ticks(10); chk("R8 halt stops", 16'(smi_seen + rst_seen), 16'h0);
        wr(5'h08, 1, 16'hFFFF);
        rd(5'h08, 1, rv); chk("R8 ctrl1 mask", rv, 16'h1F00);
        wr(5'h08, 1, 16'h0000);
        rd(5'h08, 1, rv); chk("R8 lock not cleared", rv, 16'h1000);
        wr(5'h08, 1, 16'h0800);

        // R9 data-in and data-out side effects
        wr(5'h04, 1, 16'h0000);
        wr(5'h02, 0, 16'h005A);
        chk("R9 data-in smi", {15'h0, smi_o}, 16'h1);
        rd(5'h04, 1, rv); chk("R9 status1 swsmi", rv, 16'h0002);
        wr(5'h03, 0, 16'h003C);
        chk("R9 data-out no smi", {15'h0, smi_o}, 16'h0);
        rd(5'h04, 1, rv); chk("R9 status1 dout", rv, 16'h0006);
        rd(5'h02, 1, rv); chk("R9 data half read", rv, 16'h3C5A);

        // R10 status masks
        wr(5'h04, 1, 16'hFFFF); rd(5'h04, 1, rv); chk("R10 status1 mask", rv, 16'h000E);
        wr(5'h06, 1, 16'hFFFF); rd(5'h06, 1, rv); chk("R10 status2 mask", rv, 16'h0006);
        wr(5'h04, 1, 16'h0000); rd(5'h04, 1, rv); chk("R10 status1 clear", rv, 16'h0000);

        // R3 upper stored bits with live count
        wr(5'h10, 1, 16'h0005); wr(5'h08, 1, 16'h0000);
        ticks(2);
        wr(5'h10, 1, 16'h0001); wr(5'h00, 1, 16'hFC00);
        rd(5'h00, 1, rv); chk("R3 overlay upper bits", rv, 16'hFC03);
        wr(5'h08, 1, 16'h0800);
        rd(5'h00, 1, rv); chk("R3 stopped stored", rv, 16'hFC00);

        // R11 byte lanes
        wr(5'h0C, 1, 16'hBEEF);
        rd(5'h0C, 0, rv); chk("R11 low byte", rv, 16'h00EF);
        rd(5'h0D, 0, rv); chk("R11 high byte", rv, 16'h00BE);

        // R11 random plain-register traffic against a model
        model[0] = 16'h0008; model[1] = 16'hBEEF; model[2] = 16'h0000; model[3] = 16'h0003;
        for (int it = 0; it < 60; it++) begin
            int k;
            int s;
            logic half, odd;
            logic [15:0] d;
            logic [15:0] exp;
            k = int'($urandom % 4);
            s = (k == 0) ? 5 : (k == 1) ? 6 : (k == 2) ? 7 : 9;
            half = 1'($urandom % 2);
            odd  = half ? 1'b0 : 1'($urandom % 2);
            d = 16'($urandom);
            wr(5'(s * 2 + int'(odd)), half, d);
            model[k] = model_write(model[k], s, half, odd, d);
            half = 1'($urandom % 2);
            odd  = half ? 1'b0 : 1'($urandom % 2);
            rd(5'(s * 2 + int'(odd)), half, rv);
            exp = half ? model[k] : (odd ? {8'h0, model[k][15:8]} : {8'h0, model[k][7:0]});
            chk("R11 random access", rv, exp);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule